// File: doc/BRIEF.md
# Circular-Buffer Line Delay

This block delays a stream of data words by a fixed number of enabled clock cycles. It does not use a chain of shift registers. Each incoming word goes into a synchronous dual-port RAM that is treated as a ring. A single wrapping counter supplies the write address. The read address is that counter plus a constant offset, taken modulo the ring size. A word stored at some address is therefore fetched again once the counter has moved on by (depth − offset) positions. That distance is the line length D.

The RAM read port is registered, and one further output register follows it. A word presented on an enabled edge appears at the output D+1 enabled edges later. An enable input freezes the counter, the write, the read register and the output register together. The delay is therefore measured in enabled cycles, and words presented while the enable is low are discarded.

The ring depth is a power of two set by an address-width parameter. The word width and the offset are also parameters. A further parameter zero-fills the ring at start-up, so the output is zero until the line has filled.

Top module: `line_delay_ram`

## Requirements
- R1: While `rst` is high on a clock edge, the write counter returns to address 0 and both the read register and `dout` become zero. `dout` reads zero on the cycle after reset is released.
- R2: The write address starts at 0 after reset and rises by one on every edge where `en` is high. After the last address, 2**ADDR_W − 1, it returns to 0.
- R3: The read address equals the write address plus RD_OFFSET, modulo 2**ADDR_W. Elaboration fails unless 0 < RD_OFFSET < 2**ADDR_W, so the two addresses never coincide.
- R4: Let D = 2**ADDR_W − RD_OFFSET. A word sampled on `din` at an enabled edge appears on `dout` after the (D+1)th following enabled edge, counting the storing edge as zero.
- R5: With INIT_ZERO = 1, `dout` is zero for the first D+1 enabled edges after the first reset.
- R6: The behaviour of R4 holds for the default geometry (512 words of 8 bits, offset 502, D = 10) and for other geometries. These include 16 words of 9 bits with D = 3, and the shortest line, D = 1, with RD_OFFSET = 2**ADDR_W − 1.
- R7: On an edge where `en` is low, nothing is written, the counter holds, and `dout` keeps its value. A word on `din` at that edge never appears on `dout`.
- R8: The delay of R4 stays exact after the write counter has wrapped past the end of the ring.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk  | input  | 1 | Clock; both RAM ports and all registers use its rising edge |
| rst  | input  | 1 | Synchronous active-high reset |
| en   | input  | 1 | Advance enable; when low the whole line is frozen |
| din  | input  | DATA_W | Word to be delayed |
| dout | output | DATA_W | Word that entered D+1 enabled edges earlier |

## Verification
The assertions take for granted that `rst` is asserted from time zero until after the first clock edge. They also take for granted that `en` is a clean 0 or 1 on every edge. Under those conditions the counter step, the wrap and the frozen-state properties need no history from before reset. The bench drives `rst` high at time zero for several cycles. It then changes `en` and `din` only on the falling clock edge, so every rising edge sees settled, known values. Stretches with the enable low are mixed into the stream, and during them `din` carries random data that must not appear on `dout`. Three geometries run on the same stream, long enough that every ring wraps at least four times.

// File: rtl/linedly_pkg.sv
package linedly_pkg;

    // Default geometry: 512 x 8 ring, read address 502 ahead => 10-word line
    localparam int DEF_DATA_W    = 8;
    localparam int DEF_ADDR_W    = 9;
    localparam int DEF_RD_OFFSET = 502;

    // Registers between the RAM read and the block output, beyond the RAM read register
    localparam int OUT_STAGES = 1;

    function automatic int ring_depth(input int addr_w);
        return 1 << addr_w;
    endfunction

    // Number of enabled cycles between writing an address and reading it back
    function automatic int line_length(input int addr_w, input int offset);
        return ring_depth(addr_w) - offset;
    endfunction

    // Offset must separate the two ports and stay within the ring
    function automatic bit offset_legal(input int addr_w, input int offset);
        return (offset > 0) && (offset < ring_depth(addr_w));
    endfunction

    // Total input-to-output latency in enabled edges
    function automatic int total_latency(input int addr_w, input int offset);
        return line_length(addr_w, offset) + OUT_STAGES;
    endfunction

endpackage

// File: rtl/ld_addr_gen.sv
module ld_addr_gen #(
    parameter int ADDR_W    = linedly_pkg::DEF_ADDR_W,
    parameter int RD_OFFSET = linedly_pkg::DEF_RD_OFFSET
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [ADDR_W-1:0] rd_addr
);
    localparam logic [ADDR_W-1:0] OFFSET_V = RD_OFFSET[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] LAST_A   = '1;

    logic [ADDR_W-1:0] ptr_q;

    // Free-running ring pointer; natural binary wrap gives modulo-depth
    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else if (en) begin
            ptr_q <= ptr_q + 1'b1;
        end
    end

    assign wr_addr = ptr_q;
    // Offset adder: the carry out of the top bit is dropped, giving modulo M
    assign rd_addr = ptr_q + OFFSET_V;

    p_wr_advance_r2: assert property (@(posedge clk) disable iff (rst)
        (en && (wr_addr != LAST_A)) |=> (wr_addr == ADDR_W'($past(wr_addr) + 1'b1)));

    p_wr_wrap_r2: assert property (@(posedge clk) disable iff (rst)
        (en && (wr_addr == LAST_A)) |=> (wr_addr == '0));

    p_wr_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(wr_addr));

endmodule

// File: rtl/ld_ring_ram.sv
module ld_ring_ram #(
    parameter int DATA_W    = linedly_pkg::DEF_DATA_W,
    parameter int ADDR_W    = linedly_pkg::DEF_ADDR_W,
    parameter bit INIT_ZERO = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_q
);
    localparam int DEPTH = linedly_pkg::ring_depth(ADDR_W);

    logic [DATA_W-1:0] mem [DEPTH];

    generate
        if (INIT_ZERO) begin : g_zero_fill
            initial begin
                for (int i = 0; i < DEPTH; i++) begin
                    mem[i] = '0;
                end
            end
        end
    endgenerate

    // Write port: one word per enabled cycle
    always_ff @(posedge clk) begin
        if (en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // Read port: registered, returns the content before any write of the same edge
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q <= '0;
        end else if (en) begin
            rd_q <= mem[rd_addr];
        end
    end

    p_rdq_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(rd_q));

endmodule

// File: rtl/ld_out_stage.sv
module ld_out_stage #(
    parameter int DATA_W = linedly_pkg::DEF_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [DATA_W-1:0] d,
    output logic [DATA_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (en) begin
            q <= d;
        end
    end
endmodule

// File: rtl/line_delay_ram.sv
module line_delay_ram #(
    parameter int DATA_W    = linedly_pkg::DEF_DATA_W,
    parameter int ADDR_W    = linedly_pkg::DEF_ADDR_W,
    parameter int RD_OFFSET = linedly_pkg::DEF_RD_OFFSET,
    parameter bit INIT_ZERO = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    // R3: the offset must keep the ports apart
    generate
        if (!linedly_pkg::offset_legal(ADDR_W, RD_OFFSET)) begin : g_bad_offset
            $error("line_delay_ram: RD_OFFSET must be in 1 .. 2**ADDR_W-1");
        end
    endgenerate

    logic [ADDR_W-1:0] wr_addr;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] ram_q;

    ld_addr_gen #(
        .ADDR_W    (ADDR_W),
        .RD_OFFSET (RD_OFFSET)
    ) u_addr (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .wr_addr (wr_addr),
        .rd_addr (rd_addr)
    );

    ld_ring_ram #(
        .DATA_W    (DATA_W),
        .ADDR_W    (ADDR_W),
        .INIT_ZERO (INIT_ZERO)
    ) u_ram (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .wr_addr (wr_addr),
        .wr_data (din),
        .rd_addr (rd_addr),
        .rd_q    (ram_q)
    );

    ld_out_stage #(
        .DATA_W (DATA_W)
    ) u_out (
        .clk (clk),
        .rst (rst),
        .en  (en),
        .d   (ram_q),
        .q   (dout)
    );

    p_dout_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(dout));

    p_ports_apart_r3: assert property (@(posedge clk) disable iff (rst)
        en |-> (rd_addr != wr_addr));

endmodule

// File: tb/tb_line_delay_ram.sv
`timescale 1ns/1ps
module tb_line_delay_ram;

    localparam int NCYC  = 3000;
    localparam int HIST  = 4096;
    // Geometry A: default 512x8, D=10
    localparam int AW_A = 9, W_A = 8, K_A = 502;
    // Geometry B: 16x9, D=3
    localparam int AW_B = 4, W_B = 9, K_B = 13;
    // Geometry C: 8x4, D=1 (shortest line)
    localparam int AW_C = 3, W_C = 4, K_C = 7;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en  = 1'b0;
    logic [8:0] din = '0;
    logic [W_A-1:0] dout_a;
    logic [W_B-1:0] dout_b;
    logic [W_C-1:0] dout_c;

    int checks = 0;
    int fails  = 0;
    int nen    = 0;
    logic [8:0] hist [HIST];

    always #10 clk = ~clk;

    line_delay_ram #(.DATA_W(W_A), .ADDR_W(AW_A), .RD_OFFSET(K_A), .INIT_ZERO(1'b1)) dut (
        .clk(clk), .rst(rst), .en(en), .din(din[W_A-1:0]), .dout(dout_a));
    line_delay_ram #(.DATA_W(W_B), .ADDR_W(AW_B), .RD_OFFSET(K_B), .INIT_ZERO(1'b1)) dut_b (
        .clk(clk), .rst(rst), .en(en), .din(din[W_B-1:0]), .dout(dout_b));
    line_delay_ram #(.DATA_W(W_C), .ADDR_W(AW_C), .RD_OFFSET(K_C), .INIT_ZERO(1'b1)) dut_c (
        .clk(clk), .rst(rst), .en(en), .din(din[W_C-1:0]), .dout(dout_c));

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (enabled edge %0d)", tag, act, exp, nen);
        end
    endtask

    // Expected output after nen enabled edges for a line of length d
    function automatic int expect_out(input int d, input int w);
        int idx;
        idx = nen - d - 2;
        if (idx < 0) return 0;
        return int'(hist[idx % HIST]) & ((1 << w) - 1);
    endfunction

    function automatic string tag_for(input int d, input int aw, input bit was_en, input string geo);
        if (!was_en)                      return {"R7 ", geo};
        if (nen <= d + 1)                 return {"R5 ", geo};
        if (nen > (1 << aw) + d + 1)      return {"R8 (R2,R3) ", geo};
        return {"R4 ", geo};
    endfunction

    initial begin
        int rd_a, rd_b, rd_c;
        bit last_en;
        last_en = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state visible on all geometries
        check("R1 geometry A", int'(dout_a), 0);
        check("R1 geometry B", int'(dout_b), 0);
        check("R1 geometry C", int'(dout_c), 0);
        for (int c = 0; c < NCYC; c++) begin
            // Drive for the coming edge
            en  = (($urandom % 5) != 0) || (c < 40);
            din = 9'($urandom);
            last_en = en;
            if (en) begin
                hist[nen % HIST] = din;
            end
            @(posedge clk);
            if (last_en) nen++;
            @(negedge clk);
            rd_a = int'(dout_a);
            rd_b = int'(dout_b);
            rd_c = int'(dout_c);
            check(tag_for(10, AW_A, last_en, "A"), rd_a, expect_out(10, W_A));
            check({"R6 ", tag_for(3, AW_B, last_en, "B")}, rd_b, expect_out(3, W_B));
            check({"R6 ", tag_for(1, AW_C, last_en, "C")}, rd_c, expect_out(1, W_C));
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(200000 * 20);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule